// File: doc/BRIEF.md
# Dual-Slope PWM Counter and Compare Slice

This block is one pulse-width modulation slice: a 16-bit counter that advances only on cycles where the slice is enabled and an external count-enable pulse is high, plus two compare channels, A and B, that turn the counter value into two waveforms. The counter runs in one of two modes. In trailing-edge mode it climbs to a wrap limit and then drops back to zero. In phase-correct mode it climbs to the limit and then descends, so every pulse stays centred on the bottom of the ramp whatever its width.

The wrap limit and the two compare levels come in as software-written values. The slice keeps its own working copies and reloads them only when a period ends, so software can write them at any time without producing runt pulses. A one-clock event pulse marks every period end. A direct counter write lets software set the phase, and it wins over counting in the cycle it happens.

The direction is held in a two-state machine. `DIR_UP` stays in `DIR_UP` on an ordinary count and on the *wrap* transition (trailing-edge period end). It moves to `DIR_DOWN` on the *apex turn* (phase-correct, counter at or above the limit). `DIR_DOWN` stays in `DIR_DOWN` while descending. It returns to `DIR_UP` on the *floor turn*, which is the phase-correct period end at zero, or on the *mode exit* when phase-correct is cleared while descending. The mode exit also ends the period.

Top module: `pwm_slice_core`

## Requirements
- R1: In trailing-edge mode (phase_correct=0) each step counts up by one. A step taken with the counter at or above the working limit sets the counter to 0, so the period is limit+1 steps.
- R2: In phase-correct mode (phase_correct=1) the counter climbs to the limit, holds it for one step (apex turn), descends to 0, and holds 0 for one step (floor turn). The period is 2×(limit+1) steps.
- R3: Each output is high while the counter is below that channel's working compare value. In trailing-edge mode the A and B rising edges therefore both fall at count 0.
- R4: A compare value of 0 keeps the output low for the whole period. A compare value of limit+1 keeps it high for the whole period, with no toggle.
- R5: The working limit and compare copies take the software values only at a period end: the trailing-edge wrap, the floor turn, or the mode exit. At all other times software writes have no effect on the outputs.
- R6: wrap_evt goes high for exactly one clock, in the cycle where the counter has just returned to 0 at a period end, and at no other time.
- R7: After reset the counter is 0, the working limit is 0xFFFF, both working compare values are 0, the direction is up, and wrap_evt is low.
- R8: inv_a and inv_b each invert only their own channel's output.
- R9: When b_is_input=1, out_b is held low regardless of the B compare value and of inv_b.
- R10: A counter write (ctr_wr=1) loads ctr_wdata in that cycle and takes priority over a step. That cycle produces no wrap event and no reload. With slice_en=0 or cnt_en=0 the counter and direction hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slice_en | input | 1 | Slice run enable |
| cnt_en | input | 1 | Count-enable pulse; one step per high cycle |
| phase_correct | input | 1 | 1 = up/down counting, 0 = trailing-edge |
| inv_a | input | 1 | Invert channel A output |
| inv_b | input | 1 | Invert channel B output |
| b_is_input | input | 1 | B pin used as input; silences out_b |
| sw_top | input | 16 | Software wrap limit |
| sw_cc_a | input | 16 | Software compare level, channel A |
| sw_cc_b | input | 16 | Software compare level, channel B |
| ctr_wr | input | 1 | Direct counter write strobe |
| ctr_wdata | input | 16 | Direct counter write value |
| out_a | output | 1 | Channel A waveform |
| out_b | output | 1 | Channel B waveform |
| wrap_evt | output | 1 | One-clock period-end event |
| count | output | 16 | Current counter value |

## Verification
The assertions assume that every input is synchronous to clk, free of unknowns, and stable around the rising edge. They also assume that a counter write is a single-cycle strobe and does not overlap the edge that ends a period. The bench drives all inputs on the falling edge and issues each step and each write as an isolated one-cycle pulse. It only changes the software limit and compare values or the mode in cycles where no step is taken, so every check falls at a known count and direction.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam int NCH  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;

endpackage

// File: rtl/pwm_dir_fsm.sv
module pwm_dir_fsm
    import pwm_slice_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         phase_correct,
    input  logic [W-1:0] top_w,
    input  logic         ctr_wr,
    input  logic [W-1:0] ctr_wdata,
    output logic [W-1:0] ctr,
    output logic         period_end,
    output logic         wrap_q
);

    dir_e         state, state_nx;
    logic [W-1:0] ctr_nx;
    logic         at_top, at_floor, end_cond, advance;

    assign at_top   = (ctr >= top_w);
    assign at_floor = (ctr == '0);
    assign advance  = step && !ctr_wr;

    // direction and next count
    always_comb begin
        state_nx = state;
        ctr_nx   = ctr;
        end_cond = 1'b0;
        unique case (state)
            DIR_UP: begin
                if (at_top && phase_correct) begin
                    state_nx = DIR_DOWN;
                    ctr_nx   = ctr;
                end else if (at_top) begin
                    state_nx = DIR_UP;
                    ctr_nx   = '0;
                    end_cond = 1'b1;
                end else begin
                    ctr_nx   = ctr + 1'b1;
                end
            end
            DIR_DOWN: begin
                if (at_floor || !phase_correct) begin
                    state_nx = DIR_UP;
                    ctr_nx   = '0;
                    end_cond = 1'b1;
                end else begin
                    ctr_nx   = ctr - 1'b1;
                end
            end
        endcase
    end

    assign period_end = advance && end_cond;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DIR_UP;
        end else if (advance) begin
            state <= state_nx;
        end
    end

    // counter and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr    <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= period_end;
            if (ctr_wr) begin
                ctr <= ctr_wdata;
            end else if (step) begin
                ctr <= ctr_nx;
            end
        end
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ctr_wr) |=> ($stable(ctr) && $stable(state)));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_wr |=> (ctr == $past(ctr_wdata)) && !wrap_q);

    // R6
    wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (ctr == '0) && (state == DIR_UP));

    // R1
    climb_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && state == DIR_UP && ctr < top_w) |=> (ctr == $past(ctr) + 1'b1));

    // R2
    apex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && state == DIR_UP && phase_correct && ctr >= top_w)
        |=> (ctr == $past(ctr)) && (state == DIR_DOWN) && !wrap_q);

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int           W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else if (load) begin
            q <= d;
        end
    end

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R5
    shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

endmodule

// File: rtl/pwm_cmp_ch.sv
module pwm_cmp_ch #(
    parameter int W = 16
) (
    input  logic [W-1:0] ctr,
    input  logic [W-1:0] cc,
    input  logic         inv,
    input  logic         mute,
    output logic         wave
);

    always_comb begin
        if (mute) begin
            wave = 1'b0;
        end else begin
            wave = (ctr < cc) ^ inv;
        end
    end

endmodule

// File: rtl/pwm_slice_core.sv
module pwm_slice_core
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slice_en,
    input  logic             cnt_en,
    input  logic             phase_correct,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic             b_is_input,
    input  logic [CNT_W-1:0] sw_top,
    input  logic [CNT_W-1:0] sw_cc_a,
    input  logic [CNT_W-1:0] sw_cc_b,
    input  logic             ctr_wr,
    input  logic [CNT_W-1:0] ctr_wdata,
    output logic             out_a,
    output logic             out_b,
    output logic             wrap_evt,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TOP_RST = {CNT_W{1'b1}};

    logic                         step;
    logic                         reload;
    logic [CNT_W-1:0]             top_w;
    logic [NCH-1:0][CNT_W-1:0]    cc_sw;
    logic [NCH-1:0][CNT_W-1:0]    cc_w;
    logic [NCH-1:0]               inv_v;
    logic [NCH-1:0]               mute_v;
    logic [NCH-1:0]               wave;

    assign step   = slice_en && cnt_en;
    assign cc_sw  = {sw_cc_b, sw_cc_a};
    assign inv_v  = {inv_b, inv_a};
    assign mute_v = {b_is_input, 1'b0};

    pwm_dir_fsm #(.W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (step),
        .phase_correct (phase_correct),
        .top_w         (top_w),
        .ctr_wr        (ctr_wr),
        .ctr_wdata     (ctr_wdata),
        .ctr           (count),
        .period_end    (reload),
        .wrap_q        (wrap_evt)
    );

    pwm_shadow #(.W(CNT_W), .RST(TOP_RST)) u_top_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reload),
        .d     (sw_top),
        .q     (top_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_shadow #(.W(CNT_W), .RST('0)) u_cc_shadow (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (reload),
            .d     (cc_sw[c]),
            .q     (cc_w[c])
        );

        pwm_cmp_ch #(.W(CNT_W)) u_cmp (
            .ctr  (count),
            .cc   (cc_w[c]),
            .inv  (inv_v[c]),
            .mute (mute_v[c]),
            .wave (wave[c])
        );
    end

    assign out_a = wave[CH_A];
    assign out_b = wave[CH_B];

    // R4
    zero_duty_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_w[CH_A] == '0) |-> (out_a == inv_a));

    // R4
    full_duty_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cc_w[CH_A]} == {1'b0, top_w} + 1'b1 && count <= top_w) |-> (out_a != inv_a));

    // R9
    b_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_is_input |-> !out_b);

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && !step) |=> !wrap_evt);

endmodule

// File: tb/test_pwm_slice_core.sv
module test_pwm_slice_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_en = 1'b0;
    logic        cnt_en = 1'b0;
    logic        phase_correct = 1'b0;
    logic        inv_a = 1'b0;
    logic        inv_b = 1'b0;
    logic        b_is_input = 1'b0;
    logic [15:0] sw_top = 16'd0;
    logic [15:0] sw_cc_a = 16'd0;
    logic [15:0] sw_cc_b = 16'd0;
    logic        ctr_wr = 1'b0;
    logic [15:0] ctr_wdata = 16'd0;
    logic        out_a, out_b, wrap_evt;
    logic [15:0] count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_slice_core i_pwm_slice_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .slice_en      (slice_en),
        .cnt_en        (cnt_en),
        .phase_correct (phase_correct),
        .inv_a         (inv_a),
        .inv_b         (inv_b),
        .b_is_input    (b_is_input),
        .sw_top        (sw_top),
        .sw_cc_a       (sw_cc_a),
        .sw_cc_b       (sw_cc_b),
        .ctr_wr        (ctr_wr),
        .ctr_wdata     (ctr_wdata),
        .out_a         (out_a),
        .out_b         (out_b),
        .wrap_evt      (wrap_evt),
        .count         (count)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk) cnt_en = 1'b1;
        @(negedge clk) cnt_en = 1'b0;
    endtask

    task automatic write_ctr(input logic [15:0] v);
        @(negedge clk) begin ctr_wr = 1'b1; ctr_wdata = v; end
        @(negedge clk) ctr_wr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "count", count, 0);
        check("R7", "out_a", out_a, 0);
        check("R7", "out_b", out_b, 0);
        check("R7", "wrap_evt", wrap_evt, 0);
        slice_en = 1'b1;
    endtask

    // reset limit is all ones: counter passes 0xFFFE and wraps after 0xFFFF
    task automatic t_reset_top();
        sw_top = 16'd3; sw_cc_a = 16'd1; sw_cc_b = 16'd3;
        write_ctr(16'hFFFE);
        step();
        check("R7", "count climbs to FFFF", count, 16'hFFFF);
        check("R6", "no event before limit", wrap_evt, 0);
        step();
        check("R1", "wrap to zero", count, 0);
        check("R6", "event on wrap", wrap_evt, 1);
        check("R3", "A rises at 0", out_a, 1);
        check("R3", "B rises at 0", out_b, 1);
        @(negedge clk);
        check("R6", "event lasts one clock", wrap_evt, 0);
    endtask

    task automatic t_trailing();
        for (int i = 1; i <= 8; i++) begin
            int e;
            e = i % 4;
            step();
            check("R1", "trailing count", count, e);
            check("R3", "A level", out_a, (e < 1));
            check("R3", "B level", out_b, (e < 3));
            check("R6", "event at period end", wrap_evt, (e == 0));
        end
    endtask

    task automatic t_extremes();
        sw_cc_a = 16'd0; sw_cc_b = 16'd4;
        check("R5", "A keeps old compare", out_a, 1);
        for (int i = 1; i <= 3; i++) begin
            step();
            check("R5", "B keeps old compare", out_b, (i < 3));
        end
        step();
        check("R1", "wrap", count, 0);
        for (int i = 0; i < 4; i++) begin
            if (i > 0) step();
            check("R4", "0% on A", out_a, 0);
            check("R4", "100% on B", out_b, 1);
        end
        step();
    endtask

    task automatic t_phase();
        int exp_cnt [10] = '{1, 2, 3, 3, 2, 1, 0, 0, 1, 2};
        sw_cc_a = 16'd1;
        for (int i = 0; i < 4; i++) step();
        check("R1", "back at zero", count, 0);
        phase_correct = 1'b1;
        for (int i = 0; i < 10; i++) begin
            int cc;
            step();
            if (i == 3) sw_cc_a = 16'd2;
            cc = (i >= 7) ? 2 : 1;
            check("R2", "up/down count", count, exp_cnt[i]);
            check("R2", "event only at floor turn", wrap_evt, (i == 7));
            check("R5", "A compare reloads at floor", out_a, (exp_cnt[i] < cc));
            check("R4", "B 100% in phase-correct", out_b, 1);
        end
        phase_correct = 1'b0;
    endtask

    task automatic t_invert();
        inv_a = 1'b1; inv_b = 1'b1;
        write_ctr(16'd0);
        check("R8", "A inverted at 0", out_a, 0);
        check("R8", "B inverted 100%", out_b, 0);
        step();
        check("R8", "A inverted at 1", out_a, 0);
        step();
        check("R8", "A inverted at 2", out_a, 1);
        inv_b = 1'b0;
        @(negedge clk);
        check("R8", "B alone restored", out_b, 1);
        check("R8", "A still inverted", out_a, 1);
        inv_a = 1'b0;
    endtask

    task automatic t_b_input();
        b_is_input = 1'b1;
        @(negedge clk);
        check("R9", "B silenced", out_b, 0);
        inv_b = 1'b1;
        @(negedge clk);
        check("R9", "B silenced with inversion", out_b, 0);
        check("R9", "A unaffected", out_a, 0);
        b_is_input = 1'b0; inv_b = 1'b0;
        @(negedge clk);
        check("R9", "B back", out_b, 1);
    endtask

    task automatic t_write_hold();
        @(negedge clk) begin cnt_en = 1'b1; ctr_wr = 1'b1; ctr_wdata = 16'd1; end
        @(negedge clk) begin cnt_en = 1'b0; ctr_wr = 1'b0; end
        check("R10", "write beats step", count, 1);
        check("R10", "no event on write", wrap_evt, 0);
        slice_en = 1'b0;
        step();
        check("R10", "hold while disabled", count, 1);
        write_ctr(16'd3);
        check("R10", "write while disabled", count, 3);
        slice_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", "hold without enable pulse", count, 3);
        step();
        check("R1", "at limit wraps", count, 0);
        check("R6", "event after write-set limit", wrap_evt, 1);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_reset_top();
        t_trailing();
        t_extremes();
        t_phase();
        t_invert();
        t_b_input();
        t_write_hold();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule